// File: doc/BRIEF.md
# Prioritised Interrupt Controller With Edge Latches

This block gathers 64 interrupt inputs behind a 32-bit register bus and drives one interrupt line to a host. Each source has two configuration words. Word A enables the source and sets its sense type, its priority, its target node and a fixed low code. Word B holds a per-source tag. Every cycle the block selects one winner from the enabled, pending sources whose priority passes the mask level. It latches that winner's number into a status register. A status value of 63 means that nothing is pending.

Four sources (47 to 50) can latch rising or falling edges. Software clears an edge latch by writing a command word that names the source by the low four bits of its number. All other sources sense levels only. A global detect-enable bit gates every source. A separate output-enable bit gates the host interrupt line. The block is used by configuring the sources, setting both enable bits and then reading the status byte when the line goes high.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the status register (offset 0x144) reads 63 in bits 31:24, the interrupt output is low, and the detect-enable, output-enable, mask and all configuration words read 0.
- R2: Word A of source n (offset 0x200 + 8n) and word B (offset 0x204 + 8n) read back exactly the value last written.
- R3: A source takes part only when bits 29:28 of its word A are both 1. A source with either bit clear never appears in the status.
- R4: Sense field word A bits 26:24 uses the codes 0 = level high, 1 = level low, 2 = rising edge and 3 = falling edge. On sources other than 47 to 50, the codes 2 and 3 (and 4 to 7) act as level high.
- R5: Among the qualifying pending sources, the status reports the one with the highest priority (word A bits 18:16). A tie goes to the lowest source number. Source 63 is never reported.
- R6: A source qualifies only if its priority is greater than or equal to the mask-level register (offset 0x084, bits 2:0). A mask of 0 passes every source.
- R7: An edge source (47 to 50) stays pending from the detected edge until it is cleared, even after its input returns to the idle level.
- R8: A write to offset 0x0C0 with bit 8 set clears the latch of the edge source whose low four number bits equal bits 3:0 (15 selects 47; 0, 1 and 2 select 48, 49 and 50). A write with bit 8 clear, or a write with a non-matching code, leaves every latch unchanged.
- R9: When a new edge arrives in the same cycle as a clear of that source, the latch stays set.
- R10: With detect-enable (offset 0x004 bit 0) clear, the status reads 63. The interrupt output is high only when output-enable (offset 0x444 bit 0) is set and the status is not 63.
- R11: The status register updates one clock after its pending inputs change. An edge input adds one more clock for the edge register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| src_in | input | 64 | Raw interrupt inputs, one per source |
| irq_out | output | 1 | Interrupt line to the host |

## Verification
The bench targets priority ties. A design that breaks a tie wrongly reports source 10 instead of source 3. It also targets a pending, enabled source 63. A design that lets it through reports 63 as if it were a real source, or hides source 3 behind it. For the edge sources, the bench covers a clear written with bit 8 low, a clear with another source's code, a falling-edge latch on source 47 (code 15), and an edge that lands in the same cycle as its clear. A design that gets these wrong loses a latched interrupt, or keeps one that software cleared. Other tests cover a level-low input, an edge code on a level-only source, the mask threshold and both global enables. Each of these makes a faulty design report the wrong winner, or leave the line high when it should be low.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
    localparam int NSRC      = 64;
    localparam int AW        = 12;
    localparam int DW        = 32;
    localparam int PRIO_W    = 3;
    localparam int STAT_W    = 8;
    localparam int IDX_W     = $clog2(NSRC);
    localparam int EDGE_LO   = 47;
    localparam int EDGE_HI   = 50;
    localparam logic [STAT_W-1:0] IDLE_CODE = STAT_W'(NSRC - 1);

    localparam logic [AW-1:0] OFS_DET_EN  = 12'h004;
    localparam logic [AW-1:0] OFS_MASK    = 12'h084;
    localparam logic [AW-1:0] OFS_EDGECLR = 12'h0C0;
    localparam logic [AW-1:0] OFS_STATUS  = 12'h144;
    localparam logic [AW-1:0] OFS_OUT_EN  = 12'h444;

    typedef enum logic [2:0] {
        SENSE_LVL_HI  = 3'd0,
        SENSE_LVL_LO  = 3'd1,
        SENSE_RISE    = 3'd2,
        SENSE_FALL    = 3'd3
    } sense_e;

    typedef struct packed {
        logic              en;
        sense_e            sense;
        logic [PRIO_W-1:0] prio;
    } src_cfg_t;

    function automatic logic edge_capable(input int n);
        return (n >= EDGE_LO) && (n <= EDGE_HI);
    endfunction

    function automatic src_cfg_t decode_word_a(input logic [DW-1:0] w, input int n);
        src_cfg_t c;
        logic [2:0] s;
        c.en   = (w[29:28] == 2'b11);
        s      = w[26:24];
        c.prio = w[18:16];
        if (s == 3'd1)
            c.sense = SENSE_LVL_LO;
        else if (edge_capable(n) && s == 3'd2)
            c.sense = SENSE_RISE;
        else if (edge_capable(n) && s == 3'd3)
            c.sense = SENSE_FALL;
        else
            c.sense = SENSE_LVL_HI;
        return c;
    endfunction
endpackage

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
    import ext_irq_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] word_a [N],
    output logic [DW-1:0] word_b [N],
    output logic          det_en,
    output logic          out_en,
    output logic [PRIO_W-1:0] mask_lvl,
    output logic          clr_valid,
    output logic [3:0]    clr_code
);
    localparam int SEL_W = $clog2(N);

    logic              cfg_hit;
    logic [SEL_W-1:0]  cfg_idx;

    assign cfg_hit   = bus_wr && (bus_addr[11:9] == 3'b001);
    assign cfg_idx   = bus_addr[3 +: SEL_W];
    assign clr_valid = bus_wr && (bus_addr == OFS_EDGECLR) && bus_wdata[8];
    assign clr_code  = bus_wdata[3:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            det_en   <= 1'b0;
            out_en   <= 1'b0;
            mask_lvl <= '0;
            for (int i = 0; i < N; i++) begin
                word_a[i] <= '0;
                word_b[i] <= '0;
            end
        end else begin
            if (bus_wr && bus_addr == OFS_DET_EN) det_en   <= bus_wdata[0];
            if (bus_wr && bus_addr == OFS_OUT_EN) out_en   <= bus_wdata[0];
            if (bus_wr && bus_addr == OFS_MASK)   mask_lvl <= bus_wdata[PRIO_W-1:0];
            if (cfg_hit) begin
                if (bus_addr[2]) word_b[cfg_idx] <= bus_wdata;
                else             word_a[cfg_idx] <= bus_wdata;
            end
        end
    end
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
    import ext_irq_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  src_in,
    input  src_cfg_t      cfg [N],
    input  logic          det_en,
    input  logic          clr_valid,
    input  logic [3:0]    clr_code,
    output logic [N-1:0]  pend,
    output logic [N-1:0]  latch_q
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '0;
            latch_q <= '0;
        end else begin
            prev_q <= src_in;
            for (int i = 0; i < N; i++) begin
                if (edge_capable(i)) begin
                    logic hit_edge;
                    logic hit_clr;
                    hit_edge = (cfg[i].sense == SENSE_RISE && src_in[i] && !prev_q[i]) ||
                               (cfg[i].sense == SENSE_FALL && !src_in[i] && prev_q[i]);
                    hit_clr  = clr_valid && (clr_code == 4'(i));
                    latch_q[i] <= hit_edge || (latch_q[i] && !hit_clr);
                end else begin
                    latch_q[i] <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            logic raw;
            unique case (cfg[i].sense)
                SENSE_LVL_LO:          raw = !src_in[i];
                SENSE_RISE, SENSE_FALL: raw = latch_q[i];
                default:               raw = src_in[i];
            endcase
            pend[i] = raw && cfg[i].en && det_en;
        end
    end
endmodule

// File: rtl/ext_irq_arb.sv
module ext_irq_arb
    import ext_irq_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      pend,
    input  src_cfg_t          cfg [N],
    input  logic [PRIO_W-1:0] mask_lvl,
    output logic [STAT_W-1:0] status_q
);
    logic [STAT_W-1:0] win;
    logic [PRIO_W-1:0] best;
    logic              found;

    always_comb begin
        win   = IDLE_CODE;
        best  = '0;
        found = 1'b0;
        for (int i = N - 2; i >= 0; i--) begin
            if (pend[i] && cfg[i].prio >= mask_lvl &&
                (!found || cfg[i].prio >= best)) begin
                win   = STAT_W'(i);
                best  = cfg[i].prio;
                found = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) status_q <= IDLE_CODE;
        else     status_q <= win;
    end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import ext_irq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic [11:0]   bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    input  logic [63:0]   src_in,
    output logic          irq_out
);
    logic [DW-1:0]     word_a [NSRC];
    logic [DW-1:0]     word_b [NSRC];
    src_cfg_t          cfg    [NSRC];
    logic              det_en, out_en, clr_valid;
    logic [PRIO_W-1:0] mask_lvl;
    logic [3:0]        clr_code;
    logic [NSRC-1:0]   pend, latch_q;
    logic [STAT_W-1:0] status_q;

    ext_irq_regs #(.N(NSRC)) u_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .word_a(word_a), .word_b(word_b),
        .det_en(det_en), .out_en(out_en), .mask_lvl(mask_lvl),
        .clr_valid(clr_valid), .clr_code(clr_code)
    );

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_dec
            assign cfg[g] = decode_word_a(word_a[g], g);
        end
    endgenerate

    ext_irq_detect #(.N(NSRC)) u_det (
        .clk(clk), .rst(rst), .src_in(src_in), .cfg(cfg), .det_en(det_en),
        .clr_valid(clr_valid), .clr_code(clr_code), .pend(pend), .latch_q(latch_q)
    );

    ext_irq_arb #(.N(NSRC)) u_arb (
        .clk(clk), .rst(rst), .pend(pend), .cfg(cfg), .mask_lvl(mask_lvl),
        .status_q(status_q)
    );

    assign irq_out = out_en && (status_q != IDLE_CODE);

    always_comb begin
        bus_rdata = '0;
        if (bus_addr[11:9] == 3'b001) begin
            if (bus_addr[2]) bus_rdata = word_b[bus_addr[8:3]];
            else             bus_rdata = word_a[bus_addr[8:3]];
        end else begin
            unique case (bus_addr)
                OFS_DET_EN: bus_rdata = {31'b0, det_en};
                OFS_OUT_EN: bus_rdata = {31'b0, out_en};
                OFS_MASK:   bus_rdata = {{(DW-PRIO_W){1'b0}}, mask_lvl};
                OFS_STATUS: bus_rdata = {status_q, 24'b0};
                default:    bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk
    import ext_irq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              det_en,
    input logic              out_en,
    input logic              irq_out,
    input logic [STAT_W-1:0] status_q,
    input logic [NSRC-1:0]   latch_q
);
    localparam logic [NSRC-1:0] EDGE_SET = {{(NSRC-EDGE_HI-1){1'b0}}, 4'hF, {EDGE_LO{1'b0}}};

    p_reset_idle_r1: assert property (@(posedge clk) rst |=> status_q == IDLE_CODE);
    p_detect_off_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !det_en |=> status_q == IDLE_CODE);
    p_irq_needs_oen_r10: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> out_en);
    p_latch_only_edge_r7: assert property (@(posedge clk) disable iff (rst)
        (latch_q & ~EDGE_SET) == '0);
    p_status_range_r5: assert property (@(posedge clk) disable iff (rst)
        status_q <= IDLE_CODE);
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .det_en(det_en), .out_en(out_en), .irq_out(irq_out),
    .status_q(status_q), .latch_q(latch_q)
);

// File: tb/tb_ext_irq_ctrl.sv
module tb_ext_irq_ctrl;
    logic        clk = 0;
    logic        rst;
    logic        bus_wr;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [63:0] src_in;
    logic        irq_out;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    ext_irq_ctrl dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in), .irq_out(irq_out)
    );

    localparam int NV = 10;
    localparam logic [71:0] VEC [NV] = '{
        {64'h0000_0000_0010_0000, 8'd63},
        {64'h0000_0000_0010_0008, 8'd3},
        {64'h0000_0000_0010_0408, 8'd3},
        {64'h0000_0000_0010_0400, 8'd10},
        {64'h0000_0000_0000_0008, 8'd20},
        {64'h0000_0000_4010_0008, 8'd3},
        {64'h8000_0000_0010_0000, 8'd63},
        {64'h8000_0000_0010_0008, 8'd3},
        {64'h0000_0000_0010_0020, 8'd5},
        {64'h0000_0000_0010_0028, 8'd3}
    };
    localparam logic [63:0] BASE = 64'h0000_0000_0010_0000;

    function automatic logic [31:0] mk_a(input logic en, input int sense, input int prio);
        return (en ? 32'h3000_0000 : 32'h0) | (32'(sense) << 24) | (32'(prio) << 16) | 32'hE;
    endfunction

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_stat(input string req, input logic [7:0] exp, input logic exp_irq);
        logic [31:0] d;
        rd(12'h144, d);
        check(req, {24'b0, d[31:24]}, {24'b0, exp});
        check(req, {31'b0, irq_out}, {31'b0, exp_irq});
    endtask

    task automatic set_src(input logic [63:0] v);
        @(negedge clk);
        src_in = v;
        wait_n(3);
    endtask

    initial begin
        logic [31:0] d;
        rst = 1; bus_wr = 0; bus_addr = 0; bus_wdata = 0; src_in = 0;
        wait_n(3);
        rst = 0;
        wait_n(1);

        // R1 reset state
        chk_stat("R1", 8'd63, 1'b0);
        rd(12'h004, d); check("R1", d, 0);
        rd(12'h084, d); check("R1", d, 0);
        rd(12'h444, d); check("R1", d, 0);
        rd(12'h200 + 12'(8*3), d); check("R1", d, 0);

        // configuration
        wr(12'h200 + 12'(8*3),  mk_a(1, 0, 5));
        wr(12'h200 + 12'(8*10), mk_a(1, 0, 5));
        wr(12'h200 + 12'(8*20), mk_a(1, 1, 7));
        wr(12'h200 + 12'(8*63), mk_a(1, 0, 7));
        wr(12'h200 + 12'(8*48), mk_a(1, 2, 6));
        wr(12'h200 + 12'(8*47), mk_a(1, 3, 6));
        wr(12'h200 + 12'(8*5),  mk_a(1, 2, 1));
        wr(12'h200 + 12'(8*30), mk_a(0, 0, 7));
        wr(12'h204 + 12'(8*3),  32'h0002_0003);
        // R2 read back
        rd(12'h200 + 12'(8*3), d); check("R2", d, mk_a(1, 0, 5));
        rd(12'h204 + 12'(8*3), d); check("R2", d, 32'h0002_0003);
        rd(12'h200 + 12'(8*30), d); check("R2", d, mk_a(0, 0, 7));

        src_in = BASE;
        wr(12'h444, 1);
        wr(12'h004, 1);
        wait_n(3);

        // R3 R4 R5 vector walk
        for (int i = 0; i < NV; i++) begin
            set_src(VEC[i][71:8]);
            chk_stat("R5_vec", VEC[i][7:0], VEC[i][7:0] != 8'd63);
        end

        // R6 mask level
        set_src(BASE | 64'h8);
        wr(12'h084, 6);
        wait_n(2);
        chk_stat("R6", 8'd63, 1'b0);
        set_src(64'h8);
        chk_stat("R6", 8'd20, 1'b1);
        wr(12'h084, 0);
        set_src(BASE);
        chk_stat("R6", 8'd63, 1'b0);

        // R7 rising edge latch on source 48
        set_src(BASE | (64'h1 << 48));
        chk_stat("R7", 8'd48, 1'b1);
        set_src(BASE);
        chk_stat("R7", 8'd48, 1'b1);
        // R8 no clear without bit 8, nor with wrong code
        wr(12'h0C0, 32'h0000_0000);
        wait_n(2);
        chk_stat("R8", 8'd48, 1'b1);
        wr(12'h0C0, 32'h0000_0101);
        wait_n(2);
        chk_stat("R8", 8'd48, 1'b1);
        wr(12'h0C0, 32'h0000_0100);
        wait_n(2);
        chk_stat("R8", 8'd63, 1'b0);

        // R4 R8 falling edge on source 47, cleared by code 15
        set_src(BASE | (64'h1 << 47));
        chk_stat("R4", 8'd63, 1'b0);
        set_src(BASE);
        chk_stat("R4", 8'd47, 1'b1);
        wr(12'h0C0, 32'h0000_010F);
        wait_n(2);
        chk_stat("R8", 8'd63, 1'b0);

        // R9 edge and clear in the same cycle
        set_src(BASE | (64'h1 << 48));
        set_src(BASE);
        chk_stat("R9", 8'd48, 1'b1);
        @(negedge clk);
        bus_wr = 1; bus_addr = 12'h0C0; bus_wdata = 32'h0000_0100;
        src_in = BASE | (64'h1 << 48);
        @(negedge clk);
        bus_wr = 0;
        wait_n(2);
        chk_stat("R9", 8'd48, 1'b1);
        wr(12'h0C0, 32'h0000_0100);
        wait_n(2);
        chk_stat("R9", 8'd63, 1'b0);

        // R11 status latency on a level source
        @(negedge clk);
        src_in = BASE | 64'h8;
        @(negedge clk);
        bus_addr = 12'h144;
        #1 check("R11", {24'b0, bus_rdata[31:24]}, 32'd3);

        // R10 enables
        wr(12'h444, 0);
        wait_n(2);
        chk_stat("R10", 8'd3, 1'b0);
        wr(12'h444, 1);
        wr(12'h004, 0);
        wait_n(2);
        chk_stat("R10", 8'd63, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule